// File: doc/BRIEF.md
# Dual-Mode Serial Control Register Slave

This block is the serial slave through which a host processor sets up a modem's configuration. It holds three 8-bit control registers: the low part of a carrier mark-frequency word, a general settings byte, and a test byte. Their contents drive named configuration outputs. The serial pins are sampled in the system clock domain. They are passed through two-stage synchronisers, and every bus edge is found from the synchronised levels.

The bus protocol is fixed once after each reset. It depends on the level of the serial clock line at one moment, a fixed number of system clock cycles after reset is released. A low clock line selects a select-framed protocol with 8-bit units that supports reads and writes. A high clock line selects a two-wire protocol with 9-bit units, start and stop conditions and an acknowledge bit, which supports writes only. The data output is open drain. The block only ever pulls the line low, and a pull-up outside the block provides the high level. A lock input restricts the host to the test register.

Top module: `scif_top`

## Requirements
- R1: While reset is applied, the mark byte (address 0) is C5h, the settings byte (address 1) is 2Fh and the test byte (address 2) is 00h. The outputs unpack the registers as follows: mark_word = {settings[0], mark[7:0]}, giving 453 after reset; rate_sel = settings[2:1]; bw_sel = settings[4:3]; zc_sync_en = settings[5]; timeout_dis = settings[6]; power_down = settings[7]; test_bits = the test byte.
- R2: PRESCALE cycles after reset is released, the block latches the synchronised serial clock level and raises mode_ready. A latched 0 selects the framed protocol and a latched 1 selects the two-wire protocol (mode_2wire=1). Until mode_ready rises, bus activity is ignored.
- R3: In framed mode, a low level on sel_a0 frames a transfer. Bits are captured on sclk rising edges, MSB first. The first byte is a header whose bit 0 selects write (0) or read (1); its other bits are ignored. The second byte is an address, and only its two low bits are used. Each following byte is data, and a write data byte is stored when its eighth bit is captured.
- R4: After each data byte, in either protocol, the register address advances by one, and it wraps from 2 back to 0.
- R5: In a framed read, the falling sclk edge after the address byte presents bit 7 of the addressed register. Each later falling edge presents the next bit, and the falling edge after the eighth data bit loads the next register. sdo_low is 1 exactly when a 0 is presented. The line is released (sdo_low=0) whenever sel_a0 is high.
- R6: Raising sel_a0 before a data byte is complete abandons the transfer. No register changes, and the next low period of sel_a0 starts again with a header byte.
- R7: In two-wire mode, a falling sdi while sclk is high is a start, and a rising sdi while sclk is high is a stop. Every unit is 8 bits followed by a ninth acknowledge clock. The header must be 1,0,1,0,1,1,A0,0, with A0 taken from the sel_a0 pin. The slave acknowledges the header, the address byte and each data byte by pulling the line low (sdo_low=1) during the ninth clock.
- R8: In two-wire mode, a header that does not match, or that has its read bit set, is not acknowledged. All bytes that follow it are then ignored until the next start.
- R9: While lock is 1, the mark and settings registers hold their reset values and writes to them are discarded. Writes to the test register still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Serial bus clock |
| sdi | input | 1 | Serial data in |
| sel_a0 | input | 1 | Framed mode: active-low select; two-wire mode: chip address bit A0 |
| lock | input | 1 | Restricts host writes to the test register |
| sdo_low | output | 1 | Open-drain data out: 1 pulls the line low, 0 releases it |
| mode_ready | output | 1 | Protocol choice has been latched |
| mode_2wire | output | 1 | 1 when the two-wire protocol is active |
| mark_word | output | 9 | Carrier mark word |
| rate_sel | output | 2 | Baud rate / deviation select |
| bw_sel | output | 2 | Receive bandwidth select |
| zc_sync_en | output | 1 | Zero-cross transmit sync enable |
| timeout_dis | output | 1 | Transmit timeout disable |
| power_down | output | 1 | Power-down request |
| test_bits | output | 8 | Test register contents |

## Verification
The hardest case to reach is the two-wire protocol. It exists only when sclk is held high through the sampling point after reset, so the bench runs a second reset with the clock line parked high. It then sends start and stop conditions, whose sdi edges must not be read as data. The other hard cases are reads that cross from address 2 back to 0 and a select that is raised in the middle of a byte. The bench builds both from bit-level tasks, and it checks the recovered bits and the acknowledge levels against a behavioural register model.

// File: rtl/scif_pkg.sv
package scif_pkg;

    localparam int NREG     = 3;
    localparam int TEST_IDX = 2;
    localparam logic [5:0] DEV_CODE = 6'b101011;

    localparam logic [7:0] RST_MARK = 8'hC5;
    localparam logic [7:0] RST_SETS = 8'h2F;
    localparam logic [7:0] RST_TEST = 8'h00;

    typedef enum logic [1:0] {
        PH_HDR  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_t;

    typedef struct packed {
        logic       valid;
        logic [1:0] addr;
        logic [7:0] data;
    } wr_req_t;

    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            0:       return RST_MARK;
            1:       return RST_SETS;
            default: return RST_TEST;
        endcase
    endfunction

    function automatic logic reg_lockable(input int idx);
        return idx != TEST_IDX;
    endfunction

    function automatic logic [1:0] addr_step(input logic [1:0] a);
        return (int'(a) >= NREG - 1) ? 2'd0 : a + 2'd1;
    endfunction

endpackage

// File: rtl/scif_sync.sv
module scif_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
            s3 <= '0;
        end else begin
            s1 <= din;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign lvl  = s2;
    assign rise = s2 & ~s3;
    assign fall = ~s2 & s3;
endmodule

// File: rtl/scif_mode_pick.sv
module scif_mode_pick #(
    parameter int PRESCALE = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_lvl,
    output logic ready,
    output logic two_wire
);
    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            ready    <= 1'b0;
            two_wire <= 1'b0;
        end else if (!ready) begin
            if (cnt == LAST) begin
                ready    <= 1'b1;
                two_wire <= sclk_lvl;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (ready && $past(ready)) |-> $stable(two_wire));
endmodule

// File: rtl/scif_engine.sv
module scif_engine
    import scif_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_ok,
    input  logic       two_wire,
    input  logic       sclk_lvl,
    input  logic       sclk_rise,
    input  logic       sclk_fall,
    input  logic       sdi_lvl,
    input  logic       sdi_rise,
    input  logic       sdi_fall,
    input  logic       sel_lvl,
    input  logic [7:0] rd_data,
    output logic [1:0] rd_addr,
    output wr_req_t    wr,
    output logic       sdo_low
);
    phase_t     ph;
    logic       busy;
    logic [3:0] bcnt;
    logic [7:0] sh;
    logic       rw;
    logic [1:0] adr;
    logic [7:0] tx;
    logic       tx_on, tx_load;
    logic       ack_on, ack_due;

    logic [7:0] byte_in;
    logic       hdr_ok;

    assign byte_in = {sh[6:0], sdi_lvl};
    assign hdr_ok  = (byte_in[7:1] == {DEV_CODE, sel_lvl}) && !byte_in[0];
    assign rd_addr = adr;
    assign sdo_low = two_wire ? ack_on : (tx_on & ~tx[7]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_HDR;
            busy    <= 1'b0;
            bcnt    <= '0;
            sh      <= '0;
            rw      <= 1'b0;
            adr     <= '0;
            tx      <= '0;
            tx_on   <= 1'b0;
            tx_load <= 1'b0;
            ack_on  <= 1'b0;
            ack_due <= 1'b0;
            wr      <= '0;
        end else begin
            wr.valid <= 1'b0;
            if (!mode_ok) begin
                bcnt <= '0;
            end else if (!two_wire) begin
                ack_on  <= 1'b0;
                ack_due <= 1'b0;
                if (sel_lvl) begin
                    busy    <= 1'b0;
                    ph      <= PH_HDR;
                    bcnt    <= '0;
                    tx_on   <= 1'b0;
                    tx_load <= 1'b0;
                end else begin
                    busy <= 1'b1;
                    if (sclk_rise) begin
                        sh <= byte_in;
                        if (bcnt == 4'd7) begin
                            bcnt <= '0;
                            case (ph)
                                PH_HDR: begin
                                    rw <= byte_in[0];
                                    ph <= PH_ADDR;
                                end
                                PH_ADDR: begin
                                    adr     <= byte_in[1:0];
                                    ph      <= PH_DATA;
                                    tx_load <= rw;
                                end
                                default: begin
                                    if (!rw) begin
                                        wr.valid <= 1'b1;
                                        wr.addr  <= adr;
                                        wr.data  <= byte_in;
                                    end
                                    adr     <= addr_step(adr);
                                    tx_load <= rw;
                                end
                            endcase
                        end else begin
                            bcnt <= bcnt + 4'd1;
                        end
                    end
                    if (sclk_fall) begin
                        if (tx_load) begin
                            tx      <= rd_data;
                            tx_on   <= 1'b1;
                            tx_load <= 1'b0;
                        end else begin
                            tx <= {tx[6:0], 1'b0};
                        end
                    end
                end
            end else begin
                tx_on   <= 1'b0;
                tx_load <= 1'b0;
                if (sclk_lvl && sdi_fall) begin
                    busy    <= 1'b1;
                    ph      <= PH_HDR;
                    bcnt    <= '0;
                    ack_due <= 1'b0;
                    ack_on  <= 1'b0;
                end else if (sclk_lvl && sdi_rise) begin
                    busy    <= 1'b0;
                    ack_due <= 1'b0;
                    ack_on  <= 1'b0;
                end else begin
                    if (sclk_rise && busy) begin
                        if (bcnt == 4'd8) begin
                            bcnt <= '0;
                        end else begin
                            sh   <= byte_in;
                            bcnt <= bcnt + 4'd1;
                            if (bcnt == 4'd7) begin
                                case (ph)
                                    PH_HDR: begin
                                        if (hdr_ok) begin
                                            ack_due <= 1'b1;
                                            ph      <= PH_ADDR;
                                        end else begin
                                            busy <= 1'b0;
                                        end
                                    end
                                    PH_ADDR: begin
                                        adr     <= byte_in[1:0];
                                        ph      <= PH_DATA;
                                        ack_due <= 1'b1;
                                    end
                                    default: begin
                                        wr.valid <= 1'b1;
                                        wr.addr  <= adr;
                                        wr.data  <= byte_in;
                                        adr      <= addr_step(adr);
                                        ack_due  <= 1'b1;
                                    end
                                endcase
                            end
                        end
                    end
                    if (sclk_fall) begin
                        ack_on  <= ack_due;
                        ack_due <= 1'b0;
                    end
                end
            end
        end
    end

    p_wr_gated_r2: assert property (@(posedge clk) disable iff (rst)
        wr.valid |-> mode_ok);

    p_sel_release_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_ok && !two_wire && sel_lvl) |=> !sdo_low);

    p_ack_mode_r7: assert property (@(posedge clk) disable iff (rst)
        ack_on |-> two_wire);
endmodule

// File: rtl/scif_regs.sv
module scif_regs
    import scif_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lock,
    input  wr_req_t    wr,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    output logic [7:0] q_mark,
    output logic [7:0] q_sets,
    output logic [7:0] q_test
);
    logic [7:0] regs [NREG];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst)
                regs[i] <= reg_default(i);
            else if (lock && reg_lockable(i))
                regs[i] <= reg_default(i);
            else if (wr.valid && int'(wr.addr) == i)
                regs[i] <= wr.data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++)
            if (int'(rd_addr) == i) rd_data = regs[i];
    end

    assign q_mark = regs[0];
    assign q_sets = regs[1];
    assign q_test = regs[TEST_IDX];

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_lock_chk
            if (reg_lockable(g)) begin : g_on
                p_lock_hold_r9: assert property (@(posedge clk) disable iff (rst)
                    lock |=> (regs[g] == reg_default(g)));
            end
        end
    endgenerate
endmodule

// File: rtl/scif_top.sv
module scif_top
    import scif_pkg::*;
#(
    parameter int PRESCALE = 512
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk,
    input  logic       sdi,
    input  logic       sel_a0,
    input  logic       lock,
    output logic       sdo_low,
    output logic       mode_ready,
    output logic       mode_2wire,
    output logic [8:0] mark_word,
    output logic [1:0] rate_sel,
    output logic [1:0] bw_sel,
    output logic       zc_sync_en,
    output logic       timeout_dis,
    output logic       power_down,
    output logic [7:0] test_bits
);
    logic [2:0] lvl, rise, fall;
    logic [7:0] rd_data, q_mark, q_sets, q_test;
    logic [1:0] rd_addr;
    wr_req_t    wr;

    scif_sync #(.W(3)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({sel_a0, sdi, sclk}),
        .lvl (lvl),
        .rise(rise),
        .fall(fall)
    );

    scif_mode_pick #(.PRESCALE(PRESCALE)) u_mode (
        .clk     (clk),
        .rst     (rst),
        .sclk_lvl(lvl[0]),
        .ready   (mode_ready),
        .two_wire(mode_2wire)
    );

    scif_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .mode_ok  (mode_ready),
        .two_wire (mode_2wire),
        .sclk_lvl (lvl[0]),
        .sclk_rise(rise[0]),
        .sclk_fall(fall[0]),
        .sdi_lvl  (lvl[1]),
        .sdi_rise (rise[1]),
        .sdi_fall (fall[1]),
        .sel_lvl  (lvl[2]),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr       (wr),
        .sdo_low  (sdo_low)
    );

    scif_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .lock   (lock),
        .wr     (wr),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .q_mark (q_mark),
        .q_sets (q_sets),
        .q_test (q_test)
    );

    assign mark_word   = {q_sets[0], q_mark};
    assign rate_sel    = q_sets[2:1];
    assign bw_sel      = q_sets[4:3];
    assign zc_sync_en  = q_sets[5];
    assign timeout_dis = q_sets[6];
    assign power_down  = q_sets[7];
    assign test_bits   = q_test;
endmodule

// File: tb/sim_scif_top.sv
`timescale 1ns/1ps
module sim_scif_top;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, sdi = 1'b1, sel_a0 = 1'b1, lock = 1'b0;
    logic       sdo_low, mode_ready, mode_2wire;
    logic [8:0] mark_word;
    logic [1:0] rate_sel, bw_sel;
    logic       zc_sync_en, timeout_dis, power_down;
    logic [7:0] test_bits;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] mdl [3];
    logic [7:0] wd [4];
    logic [7:0] rdv [4];

    always #2.5 clk = ~clk;

    scif_top u0 (
        .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .sel_a0(sel_a0), .lock(lock),
        .sdo_low(sdo_low), .mode_ready(mode_ready), .mode_2wire(mode_2wire),
        .mark_word(mark_word), .rate_sel(rate_sel), .bw_sel(bw_sel),
        .zc_sync_en(zc_sync_en), .timeout_dis(timeout_dis), .power_down(power_down),
        .test_bits(test_bits)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        check(tag, {8'h00, power_down, timeout_dis, zc_sync_en, bw_sel, rate_sel,
                    mark_word[8], mark_word[7:0], test_bits},
              {8'h00, mdl[1], mdl[0], mdl[2]});
    endtask

    task automatic model_defaults();
        mdl[0] = 8'hC5; mdl[1] = 8'h2F; mdl[2] = 8'h00;
    endtask

    task automatic model_write(input int a, input logic [7:0] d);
        if (a < 3 && !(lock && a != 2)) mdl[a] = d;
    endtask

    task automatic do_reset(input logic park_sclk);
        rst = 1'b1; sclk = park_sclk; sdi = 1'b1; sel_a0 = 1'b1;
        tick(8);
        rst = 1'b0;
        model_defaults();
    endtask

    task automatic fbyte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            sdi = b[i];
            tick(H);
            r[i] = ~sdo_low;
            sclk = 1'b1;
            tick(H);
            sclk = 1'b0;
        end
    endtask

    task automatic fxfer(input logic [6:0] hjunk, input logic rw, input logic [7:0] adr, input int n);
        logic [7:0] dummy;
        sel_a0 = 1'b0;
        tick(H);
        fbyte({hjunk, rw}, dummy);
        fbyte(adr, dummy);
        for (int k = 0; k < n; k++) fbyte(wd[k], rdv[k]);
        tick(H);
        sel_a0 = 1'b1;
        tick(H);
    endtask

    task automatic tw_start();
        sdi = 1'b1; sclk = 1'b1; tick(H);
        sdi = 1'b0; tick(H);
        sclk = 1'b0; tick(H);
    endtask

    task automatic tw_stop();
        sdi = 1'b0; tick(H);
        sclk = 1'b1; tick(H);
        sdi = 1'b1; tick(H);
    endtask

    task automatic tw_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sdi = b[i]; tick(H);
            sclk = 1'b1; tick(H);
            sclk = 1'b0; tick(3);
        end
        sdi = 1'b1; tick(H);
        ack = sdo_low;
        sclk = 1'b1; tick(H);
        sclk = 1'b0; tick(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic a0, a1, a2, a3;
        // ---------------- framed mode ----------------
        do_reset(1'b0);
        tick(1);
        check_regs("R1 reset register values");
        check("R1 mark word 453", {23'd0, mark_word}, 32'd453);
        check("R5 line released after reset", {31'd0, sdo_low}, 32'd0);
        tick(100);
        check("R2 not ready early", {31'd0, mode_ready}, 32'd0);
        tick(450);
        check("R2 ready framed", {30'd0, mode_ready, mode_2wire}, 32'b10);

        wd[0] = 8'h3C;
        fxfer(7'h00, 1'b0, 8'h02, 1);
        model_write(2, 8'h3C);
        check_regs("R3 single write test reg");

        wd[0] = 8'h5A; wd[1] = 8'h81; wd[2] = 8'h44;
        fxfer(7'h7F, 1'b0, 8'hFD, 3);
        model_write(1, 8'h5A); model_write(2, 8'h81); model_write(0, 8'h44);
        check_regs("R4 R3 sequential write wraps, header junk and address high bits ignored");

        wd[0] = 8'h00;
        fxfer(7'h15, 1'b1, 8'h00, 1);
        check("R5 single read addr 0", {24'd0, rdv[0]}, {24'd0, mdl[0]});
        check("R5 line released after read", {31'd0, sdo_low}, 32'd0);
        check_regs("R3 read leaves registers");

        wd[0] = 8'hFF; wd[1] = 8'hFF; wd[2] = 8'hFF;
        fxfer(7'h00, 1'b1, 8'h02, 3);
        check("R4 R5 read addr 2", {24'd0, rdv[0]}, {24'd0, mdl[2]});
        check("R4 R5 read wraps to 0", {24'd0, rdv[1]}, {24'd0, mdl[0]});
        check("R4 R5 read addr 1", {24'd0, rdv[2]}, {24'd0, mdl[1]});

        // abort mid data byte
        begin
            logic [7:0] dmy;
            sel_a0 = 1'b0; tick(H);
            fbyte(8'h00, dmy);
            fbyte(8'h02, dmy);
            for (int i = 7; i >= 3; i--) begin
                sdi = 1'b1; tick(H); sclk = 1'b1; tick(H); sclk = 1'b0;
            end
            tick(H); sel_a0 = 1'b1; tick(2 * H);
        end
        check_regs("R6 aborted byte changes nothing");
        wd[0] = 8'hA7;
        fxfer(7'h00, 1'b0, 8'h02, 1);
        model_write(2, 8'hA7);
        check_regs("R6 framing restarts after abort");

        lock = 1'b1;
        tick(2);
        mdl[0] = 8'hC5; mdl[1] = 8'h2F;
        check_regs("R9 lock restores defaults");
        wd[0] = 8'h11; wd[1] = 8'h22; wd[2] = 8'h33;
        fxfer(7'h00, 1'b0, 8'h00, 3);
        model_write(0, 8'h11); model_write(1, 8'h22); model_write(2, 8'h33);
        check_regs("R9 only test reg writable under lock");
        lock = 1'b0;
        tick(2);
        check_regs("R9 values kept after unlock");

        // ---------------- two-wire mode ----------------
        do_reset(1'b1);
        tick(560);
        check("R2 ready two-wire", {30'd0, mode_ready, mode_2wire}, 32'b11);
        check_regs("R1 defaults in two-wire mode");
        sel_a0 = 1'b1;
        tick(4);

        tw_start();
        tw_byte(8'hAE, a0);
        tw_byte(8'h02, a1);
        tw_byte(8'h96, a2);
        tw_byte(8'h4B, a3);
        tw_stop();
        model_write(2, 8'h96); model_write(0, 8'h4B);
        check("R7 acks header addr data data", {28'd0, a0, a1, a2, a3}, 32'hF);
        check_regs("R7 R4 two-wire sequential write wraps");
        check("R7 line released after stop", {31'd0, sdo_low}, 32'd0);

        tw_start();
        tw_byte(8'hAC, a0);
        tw_byte(8'h02, a1);
        tw_byte(8'h12, a2);
        tw_stop();
        check("R8 wrong chip address no ack", {29'd0, a0, a1, a2}, 32'd0);
        check_regs("R8 wrong chip address writes nothing");

        tw_start();
        tw_byte(8'hAF, a0);
        tw_byte(8'h01, a1);
        tw_byte(8'h12, a2);
        tw_stop();
        check("R8 read header no ack", {29'd0, a0, a1, a2}, 32'd0);
        check_regs("R8 read header writes nothing");

        sel_a0 = 1'b0;
        tick(4);
        tw_start();
        tw_byte(8'hAC, a0);
        tw_byte(8'h01, a1);
        tw_byte(8'h6D, a2);
        tw_stop();
        model_write(1, 8'h6D);
        check("R7 A0 pin low matches header", {29'd0, a0, a1, a2}, 32'h7);
        check_regs("R7 write with A0 low");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule